// File: doc/BRIEF.md
# Paced Round-Robin Short-Request Arbiter

Five independent sources each offer a short request to a memory access unit. A source offers a request by holding its request line together with four fields: an operation code, a register number, a size bit that selects a 32-byte or a 64-byte transfer, and an upper-half select bit. The arbiter picks one requesting source per grant. Priority rotates, so the source after the last winner is considered first. In the cycle it issues, the arbiter acknowledges the winner and drives the request to the memory side.

The issue rate depends on the size of the last issued request. After a 32-byte issue, the next grant comes two cycles later at the earliest. After a 64-byte issue, it comes four cycles later at the earliest. Two valid lines tell the memory side which half of the cache row a request addresses. A 64-byte request raises both lines. A 32-byte request raises only the line picked by its upper-half bit.

Operation codes below 3 are illegal. Such a request is acknowledged and thrown away, and an error pulse marks it. It uses no pacing slot.

Top module: `paced_rr_arb`

## Requirements
- R1: While rst_ni is low, every output is 0, and the rotating pointer is at source 0.
- R2: Decisions are made at a rising clock edge from the inputs present at that edge, and the outputs hold the result for the following cycle. At most one ack_o bit is set, and only for a source whose req_i bit was high at that edge. No grant is made while the pacing window is still open.
- R3: The winner is the first requesting source found by counting upward from the pointer, wrapping from 4 to 0. After every grant, legal or illegal, the pointer moves to the winner plus one, modulo 5.
- R4: A legal 32-byte request (wide_i bit = 0) is issued. The next cycle carries no ack_o, so the next grant is at least 2 cycles after the issue.
- R5: A legal 64-byte request (wide_i bit = 1) is issued. The next three cycles carry no ack_o, so the next grant is at least 4 cycles after the issue.
- R6: A legal 64-byte issue sets both row_lo_vld_o and row_hi_vld_o. A legal 32-byte issue sets row_hi_vld_o when the source's upper_i bit is 1 and row_lo_vld_o when it is 0.
- R7: During a legal issue, op_o and reg_o carry the winner's fields. Source s drives op_i[3s+2:3s] and reg_i[5s+4:5s]. Legal codes are 3 (clear load register), 4 (coherent answer), 5 (clear store register), 6 (send from store register) and 7 (send from and clear store register). When no legal issue is taking place, op_o and reg_o are 0.
- R8: A granted request with an operation code from 0 to 2 gets its ack_o pulse and raises err_o for one cycle. It raises no valid line and opens no pacing window, so a grant can follow in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 5 | Request line of each source |
| wide_i | input | 5 | Per source: 1 = 64-byte request, 0 = 32-byte request |
| upper_i | input | 5 | Per source: half select for a 32-byte request, 1 = upper half |
| op_i | input | 15 | Operation code of each source, 3 bits per source |
| reg_i | input | 25 | Register number of each source, 5 bits per source |
| ack_o | output | 5 | One-cycle acknowledge to the winning source |
| row_lo_vld_o | output | 1 | Request addresses the lower half of the cache row |
| row_hi_vld_o | output | 1 | Request addresses the upper half of the cache row |
| op_o | output | 3 | Operation code of the issued request |
| reg_o | output | 5 | Register number of the issued request |
| err_o | output | 1 | Pulse for a dropped illegal request |

## Verification
The assertions check, on every cycle:
- that at most one acknowledge is raised, and only for a source that was requesting;
- that the two pacing gaps hold after each issue;
- that the error pulse never coincides with a valid line;
- that op_o and reg_o are zero on idle cycles and carry only legal codes on issue cycles.

Some behaviour only the bench's scenarios can show. This covers which source wins under rotation, whether the forwarded fields are the winner's own, and which half lines a 32-byte request raises. It also covers an illegal request that opens no pacing window. For these, the bench compares a behavioural model on every cycle and replays directed sweeps in which all sources request at once.

// File: rtl/paced_rr_arb_pkg.sv
package paced_rr_arb_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_CLR_LOAD   = 3'd3,
    OP_COH_ANSWER = 3'd4,
    OP_CLR_STORE  = 3'd5,
    OP_SEND_STORE = 3'd6,
    OP_SEND_CLR   = 3'd7
  } op_e;

  localparam logic [OP_W-1:0] OP_FIRST_LEGAL = OP_CLR_LOAD;

  function automatic logic op_legal(input logic [OP_W-1:0] op);
    return op >= OP_FIRST_LEGAL;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N_SRC = 5,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W:0] pos;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    pos   = '0;
    for (int k = 0; k < N_SRC; k++) begin
      pos = {1'b0, ptr_i} + (IDX_W+1)'(k);
      if (pos >= (IDX_W+1)'(N_SRC)) pos = pos - (IDX_W+1)'(N_SRC);
      if (!any_o && req_i[pos]) begin
        any_o = 1'b1;
        idx_o = pos[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pace_ctr.sv
module pace_ctr #(
  parameter int unsigned SHORT_GAP = 2,
  parameter int unsigned LONG_GAP  = 4,
  localparam int unsigned CW = (LONG_GAP > 2) ? $clog2(LONG_GAP) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic long_i,
  output logic ready_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= long_i ? CW'(LONG_GAP - 1) : CW'(SHORT_GAP - 1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);
endmodule

// File: rtl/paced_rr_arb.sv
module paced_rr_arb
  import paced_rr_arb_pkg::*;
#(
  parameter int unsigned N_SRC     = 5,
  parameter int unsigned REG_W     = 5,
  parameter int unsigned SHORT_GAP = 2,
  parameter int unsigned LONG_GAP  = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC-1:0]       wide_i,
  input  logic [N_SRC-1:0]       upper_i,
  input  logic [N_SRC*OP_W-1:0]  op_i,
  input  logic [N_SRC*REG_W-1:0] reg_i,
  output logic [N_SRC-1:0]       ack_o,
  output logic                   row_lo_vld_o,
  output logic                   row_hi_vld_o,
  output logic [OP_W-1:0]        op_o,
  output logic [REG_W-1:0]       reg_o,
  output logic                   err_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SRC - 1);

  logic [OP_W-1:0]  op_a  [N_SRC];
  logic [REG_W-1:0] reg_a [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
    assign op_a[g]  = op_i[g*OP_W +: OP_W];
    assign reg_a[g] = reg_i[g*REG_W +: REG_W];
  end

  logic [IDX_W-1:0] ptr_q, win;
  logic any, ready, grant, legal;
  logic [OP_W-1:0] win_op;
  logic [N_SRC-1:0] win_oh;

  rr_pick #(.N_SRC(N_SRC)) i_pick (
    .req_i (req_i),
    .ptr_i (ptr_q),
    .any_o (any),
    .idx_o (win)
  );

  assign grant  = ready && any;
  assign win_op = op_a[win];
  assign legal  = op_legal(win_op);
  assign win_oh = N_SRC'(1) << win;

  pace_ctr #(.SHORT_GAP(SHORT_GAP), .LONG_GAP(LONG_GAP)) i_pace (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (grant && legal),
    .long_i  (wide_i[win]),
    .ready_o (ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q        <= '0;
      ack_o        <= '0;
      row_lo_vld_o <= 1'b0;
      row_hi_vld_o <= 1'b0;
      op_o         <= '0;
      reg_o        <= '0;
      err_o        <= 1'b0;
    end else begin
      ack_o        <= grant ? win_oh : '0;
      row_lo_vld_o <= grant && legal && (wide_i[win] || !upper_i[win]);
      row_hi_vld_o <= grant && legal && (wide_i[win] ||  upper_i[win]);
      op_o         <= (grant && legal) ? win_op : '0;
      reg_o        <= (grant && legal) ? reg_a[win] : '0;
      err_o        <= grant && !legal;
      if (grant) ptr_q <= (win == LAST) ? '0 : win + 1'b1;
    end
  end
endmodule

// File: rtl/paced_rr_arb_chk.sv
module paced_rr_arb_chk #(
  parameter int unsigned N_SRC = 5,
  parameter int unsigned OP_W  = 3,
  parameter int unsigned REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic [N_SRC-1:0] ack_o,
  input logic             row_lo_vld_o,
  input logic             row_hi_vld_o,
  input logic [OP_W-1:0]  op_o,
  input logic [REG_W-1:0] reg_o,
  input logic             err_o
);
  logic issue, issue_long;
  assign issue      = row_lo_vld_o || row_hi_vld_o;
  assign issue_long = row_lo_vld_o && row_hi_vld_o;

  assert_ack_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assert_ack_had_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ack_o[i] |-> $past(req_i[i]));
  end

  assert_short_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |=> (ack_o == '0));

  assert_long_gap2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_long |=> ##1 (ack_o == '0));

  assert_long_gap3_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_long |=> ##2 (ack_o == '0));

  assert_issue_fields_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue |-> (op_o >= OP_W'(3)) && $onehot(ack_o));

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue |-> (op_o == '0) && (reg_o == '0));

  assert_err_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !issue && $onehot(ack_o));
endmodule

bind paced_rr_arb paced_rr_arb_chk #(.N_SRC(N_SRC), .OP_W(paced_rr_arb_pkg::OP_W), .REG_W(REG_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .ack_o        (ack_o),
  .row_lo_vld_o (row_lo_vld_o),
  .row_hi_vld_o (row_hi_vld_o),
  .op_o         (op_o),
  .reg_o        (reg_o),
  .err_o        (err_o)
);

// File: tb/test_paced_rr_arb.sv
module test_paced_rr_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, wide = '0, upper = '0;
  logic [N*3-1:0] op = '0;
  logic [N*5-1:0] rg = '0;
  logic [N-1:0] ack;
  logic lo, hi, err;
  logic [2:0] op_out;
  logic [4:0] reg_out;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // model state
  int m_ptr = 0, m_cnt = 0;
  int e_ack = 0, e_lo = 0, e_hi = 0, e_op = 0, e_reg = 0, e_err = 0;
  int ack_src[$];
  int ack_cyc[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  paced_rr_arb i_paced_rr_arb (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wide_i(wide), .upper_i(upper),
    .op_i(op), .reg_i(rg), .ack_o(ack), .row_lo_vld_o(lo), .row_hi_vld_o(hi),
    .op_o(op_out), .reg_o(reg_out), .err_o(err)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; m_cnt = 0;
      e_ack = 0; e_lo = 0; e_hi = 0; e_op = 0; e_reg = 0; e_err = 0;
    end else begin
      int w;
      w = -1;
      e_ack = 0; e_lo = 0; e_hi = 0; e_op = 0; e_reg = 0; e_err = 0;
      if (m_cnt == 0) begin
        for (int k = 0; k < N; k++)
          if (w < 0 && req[(m_ptr + k) % N]) w = (m_ptr + k) % N;
      end else m_cnt--;
      if (w >= 0) begin
        int o;
        o = int'(op[w*3 +: 3]);
        e_ack = 1 << w;
        if (o < 3) e_err = 1;
        else begin
          e_op = o; e_reg = int'(rg[w*5 +: 5]);
          e_lo = (wide[w] || !upper[w]) ? 1 : 0;
          e_hi = (wide[w] ||  upper[w]) ? 1 : 0;
          m_cnt = wide[w] ? 3 : 1;
        end
        m_ptr = (w + 1) % N;
      end
    end
  end

  // per-cycle compare and acknowledge log
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(int'(ack) == e_ack, "R2/R3", "ack", int'(ack), e_ack);
      chk(int'(lo) == e_lo && int'(hi) == e_hi, "R6", "half lines", int'({lo, hi}), (e_lo << 1) | e_hi);
      chk(int'(op_out) == e_op && int'(reg_out) == e_reg, "R7", "op/reg",
          int'({op_out, reg_out}), (e_op << 5) | e_reg);
      chk(int'(err) == e_err, "R8", "err", int'(err), e_err);
      for (int s = 0; s < N; s++)
        if (ack[s]) begin ack_src.push_back(s); ack_cyc.push_back(cyc); end
    end
  end

  task automatic set_all(input bit w, input bit u, input int code);
    for (int s = 0; s < N; s++) begin
      wide[s] = w; upper[s] = u;
      op[s*3 +: 3] = 3'(code);
      rg[s*5 +: 5] = 5'(s + 8);
    end
  endtask

  task automatic sweep(input int gap, input string rq);
    ack_src.delete(); ack_cyc.delete();
    req = '1;
    repeat (5 * gap) @(negedge clk);
    req = '0;
    repeat (gap + 1) @(negedge clk);
    chk(ack_src.size() == 5, rq, "grant count", ack_src.size(), 5);
    for (int i = 0; i < ack_src.size() && i < 5; i++) begin
      chk(ack_src[i] == i, "R3", "rotation order", ack_src[i], i);
      if (i > 0) chk(ack_cyc[i] - ack_cyc[i-1] == gap, rq, "grant spacing", ack_cyc[i] - ack_cyc[i-1], gap);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ack == '0 && !lo && !hi && !err && op_out == 0 && reg_out == 0, "R1", "reset outputs",
        int'({ack, lo, hi, err}), 0);
    rst_n = 1'b1;

    // R3/R4: all sources, 32-byte, lower half; pointer starts at 0
    set_all(1'b0, 1'b0, 4);
    sweep(2, "R4");
    // R5: all sources, 64-byte
    set_all(1'b1, 1'b0, 6);
    sweep(4, "R5");
    // R6: 32-byte upper half
    set_all(1'b0, 1'b1, 7);
    sweep(2, "R6");

    // R8: illegal drop opens no pacing window
    ack_src.delete(); ack_cyc.delete();
    set_all(1'b1, 1'b0, 1);
    req = 5'b00100;
    @(negedge clk);
    op[3*3 +: 3] = 3'd5;
    req = 5'b01000;
    @(negedge clk);
    req = '0;
    repeat (6) @(negedge clk);
    chk(ack_src.size() == 2, "R8", "grant count", ack_src.size(), 2);
    if (ack_src.size() == 2)
      chk(ack_cyc[1] - ack_cyc[0] == 1, "R8", "no pacing after drop", ack_cyc[1] - ack_cyc[0], 1);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      req = 5'($urandom);
      wide = 5'($urandom);
      upper = 5'($urandom);
      for (int s = 0; s < N; s++) begin
        op[s*3 +: 3] = ($urandom % 6 == 0) ? 3'($urandom % 3) : 3'(3 + $urandom % 5);
        rg[s*5 +: 5] = 5'($urandom);
      end
      @(negedge clk);
    end
    req = '0;
    repeat (5) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule